// File: doc/BRIEF.md
# Sliding-Table Operand Address Unit

This unit walks a table of 16-bit words held in a small internal word memory addressed in bytes. On every step it presents the word at the current pointer to the arithmetic datapath. It then moves the pointer by one word (up or down) or by a programmable even byte offset (up or down). In the same clock edge it stores the word it just read at the mirror-image address: the pointer moved the opposite way by the same amount. Over a run of steps the stored table slides by one word position while the computation consumes it, which is how a filter delay line ages its samples without separate copy operations.

A load port sets the pointer, the offset and individual memory words. Any load cycle takes priority over a step, and a step requested in a load cycle is dropped. The memory holds 64 words. Byte address bit 0 is not used, and higher address bits wrap modulo the memory size. The pointer and offset are full 16-bit registers, and their arithmetic wraps modulo 2^16.

Top module: `pdm_addr_unit`

## Requirements
- R1: A synchronous active-low reset clears the pointer and the offset to zero, and reset overrides any load in the same cycle.
- R2: `rd_data_o` always shows the memory word selected by pointer bits [6:1]. Bit 0 and bits above 6 do not affect the selection, so byte address 128 reads word 0.
- R3: Mode 2'b00 (word up): a step adds 2 to the pointer and writes the word read in that cycle to pointer minus 2.
- R4: Mode 2'b01 (word down): a step subtracts 2 from the pointer and writes the word read to pointer plus 2.
- R5: Mode 2'b10 (offset up): a step adds the offset to the pointer and writes the word read to pointer minus offset.
- R6: Mode 2'b11 (offset down): a step subtracts the offset from the pointer and writes the word read to pointer plus offset.
- R7: Loading the offset stores the value with bit 0 forced to 0, so the offset is always an even byte count.
- R8: A memory load writes `ld_data_i` to the word selected by `ld_addr_i` bits [6:1]. Bit 0 and bits above 6 are ignored.
- R9: In a cycle with any load asserted, a requested step has no effect: the pointer takes only the loaded value (or keeps its value), and no write-back happens.
- R10: `wb_addr_o` shows, in every cycle, the write-back address that a step in that cycle would use. It is the pointer moved by the mode's amount in the direction opposite to the pointer update.
- R11: With `step_i` low and no load, the pointer and the memory contents keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | Perform one read, write-back and pointer update |
| mode_i | input | 2 | Step mode: 00 word up, 01 word down, 10 offset up, 11 offset down |
| ld_ptr_i | input | 1 | Load the pointer |
| ld_ptr_val_i | input | 16 | Pointer load value (byte address) |
| ld_off_i | input | 1 | Load the offset |
| ld_off_val_i | input | 16 | Offset load value (bit 0 dropped) |
| ld_mem_i | input | 1 | Write one memory word from the load port |
| ld_addr_i | input | 16 | Byte address for the memory load |
| ld_data_i | input | 16 | Data for the memory load |
| rd_data_o | output | 16 | Word at the current pointer |
| ptr_o | output | 16 | Current pointer |
| wb_addr_o | output | 16 | Write-back address for a step in this cycle |

## Verification
The single memory write port is shared by two functions: the step's write-back and the load port's word write. They collide when `step_i` and `ld_mem_i` are raised together. The bench provokes this in directed cycles, where the write-back target and the load target are both the same word and different words, and again at random during a long mixed run. The reference model judges the result, since it applies only the load and leaves the pointer untouched. A second coincidence, the write-back landing on the word being read (offset zero), is provoked directly. After every scenario the whole table is read back through the pointer.

// File: rtl/pdm_pkg.sv
// Shared definitions for the sliding-table address unit.
// Mode encoding: bit 1 selects the step amount (0 = one word, 1 = offset),
// bit 0 selects the direction of the pointer update (0 = up, 1 = down).
package pdm_pkg;

    typedef enum logic [1:0] {
        PDM_WORD_UP  = 2'b00,
        PDM_WORD_DN  = 2'b01,
        PDM_OFFS_UP  = 2'b10,
        PDM_OFFS_DN  = 2'b11
    } pdm_mode_e;

    // Bytes per table word.
    localparam int PDM_WORD_BYTES = 2;

endpackage

// File: rtl/pdm_addr_calc.sv
// Combinational pointer arithmetic.
// Computes the next pointer and the mirror write-back address from the current
// pointer, the offset register and the mode. The write-back address applies the
// same amount as the pointer update, in the opposite direction.
// Assumes: all arithmetic wraps modulo 2^PW.
module pdm_addr_calc
    import pdm_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic [PW-1:0] ptr_i,
    input  logic [PW-1:0] off_i,
    input  pdm_mode_e     mode_i,
    output logic [PW-1:0] nxt_ptr_o,
    output logic [PW-1:0] wb_addr_o
);

    localparam logic [PW-1:0] WORD_STEP = PW'(PDM_WORD_BYTES);

    logic [PW-1:0] amount;
    logic          go_down;
    logic [PW-1:0] ptr_plus;
    logic [PW-1:0] ptr_minus;

    // Select the step amount from the mode.
    always_comb begin
        amount  = mode_i[1] ? off_i : WORD_STEP;
        go_down = mode_i[0];
    end

    // Form both directions once, then steer them to the two results.
    always_comb begin
        ptr_plus  = ptr_i + amount;
        ptr_minus = ptr_i - amount;
        nxt_ptr_o = go_down ? ptr_minus : ptr_plus;
        wb_addr_o = go_down ? ptr_plus  : ptr_minus;
    end

endmodule

// File: rtl/pdm_regs.sv
// Pointer and offset registers.
// Loads take effect on the clock edge. A step advances the pointer only when
// adv_i is high; the caller guarantees adv_i is low in any load cycle.
// The offset is kept even by dropping bit 0 of the load value.
// Assumes: synchronous active-low reset.
module pdm_regs #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_ptr_i,
    input  logic [PW-1:0] ld_ptr_val_i,
    input  logic          ld_off_i,
    input  logic [PW-1:0] ld_off_val_i,
    input  logic          adv_i,
    input  logic [PW-1:0] nxt_ptr_i,
    output logic [PW-1:0] ptr_o,
    output logic [PW-1:0] off_o
);

    // Pointer: reset, load, or step advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o <= '0;
        end else if (ld_ptr_i) begin
            ptr_o <= ld_ptr_val_i;
        end else if (adv_i) begin
            ptr_o <= nxt_ptr_i;
        end
    end

    // Offset: reset or load with bit 0 cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_o <= '0;
        end else if (ld_off_i) begin
            off_o <= {ld_off_val_i[PW-1:1], 1'b0};
        end
    end

endmodule

// File: rtl/pdm_word_mem.sv
// Word memory with one asynchronous read port and one synchronous write port.
// Ports take word indices; the caller drops the byte-select bit.
// Assumes: contents are not reset and are initialised through the write port.
module pdm_word_mem #(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [IW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [IW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem_q [DEPTH];

    // Write one word on the clock edge.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Present the addressed word without delay.
    always_comb begin
        rdata_o = mem_q[raddr_i];
    end

endmodule

// File: rtl/pdm_addr_unit.sv
// Sliding-table operand address unit (top).
// Each step reads the word at the pointer, moves the pointer per mode and,
// on the same edge, writes the read word to the mirror-image address. A load
// cycle (pointer, offset or memory) suppresses the step entirely, and the load
// port owns the single memory write port in that cycle.
// Assumes: byte addressing with 2-byte words; memory index is pointer
// bits [IW:1], so addresses wrap modulo the memory size.
module pdm_addr_unit
    import pdm_pkg::*;
#(
    parameter int PW    = 16,
    parameter int DW    = 16,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [1:0]    mode_i,
    input  logic          ld_ptr_i,
    input  logic [PW-1:0] ld_ptr_val_i,
    input  logic          ld_off_i,
    input  logic [PW-1:0] ld_off_val_i,
    input  logic          ld_mem_i,
    input  logic [PW-1:0] ld_addr_i,
    input  logic [DW-1:0] ld_data_i,
    output logic [DW-1:0] rd_data_o,
    output logic [PW-1:0] ptr_o,
    output logic [PW-1:0] wb_addr_o
);

    localparam int IW = $clog2(DEPTH);

    logic          any_ld;
    logic          step_go;
    pdm_mode_e     mode_e;
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] off_q;
    logic [PW-1:0] nxt_ptr;
    logic [PW-1:0] wb_addr;
    logic [DW-1:0] rd_word;
    logic          mem_we;
    logic [IW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic          unused_addr_bits;

    // Loads win over a step in the same cycle.
    always_comb begin
        any_ld  = ld_ptr_i | ld_off_i | ld_mem_i;
        step_go = step_i & ~any_ld;
        mode_e  = pdm_mode_e'(mode_i);
    end

    pdm_regs #(.PW(PW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_ptr_i     (ld_ptr_i),
        .ld_ptr_val_i (ld_ptr_val_i),
        .ld_off_i     (ld_off_i),
        .ld_off_val_i (ld_off_val_i),
        .adv_i        (step_go),
        .nxt_ptr_i    (nxt_ptr),
        .ptr_o        (ptr_q),
        .off_o        (off_q)
    );

    pdm_addr_calc #(.PW(PW)) u_calc (
        .ptr_i     (ptr_q),
        .off_i     (off_q),
        .mode_i    (mode_e),
        .nxt_ptr_o (nxt_ptr),
        .wb_addr_o (wb_addr)
    );

    // Share the memory write port: the load port first, else the write-back.
    always_comb begin
        mem_we    = ld_mem_i | step_go;
        mem_waddr = ld_mem_i ? ld_addr_i[IW:1] : wb_addr[IW:1];
        mem_wdata = ld_mem_i ? ld_data_i : rd_word;
    end

    pdm_word_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (ptr_q[IW:1]),
        .rdata_o (rd_word)
    );

    // Byte-select and wrap bits of the load address carry no meaning.
    always_comb begin
        unused_addr_bits = ^{ld_addr_i[0], ld_addr_i[PW-1:IW+1]};
    end

    // Drive the outputs.
    always_comb begin
        rd_data_o = rd_word;
        ptr_o     = ptr_q;
        wb_addr_o = wb_addr;
    end

endmodule

// File: rtl/pdm_addr_unit_chk.sv
// Property checker for pdm_addr_unit, attached by bind below.
// Watches the ports and the offset register across clock edges.
module pdm_addr_unit_chk #(
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step_i,
    input logic [1:0]    mode_i,
    input logic          ld_ptr_i,
    input logic          ld_off_i,
    input logic          ld_mem_i,
    input logic [PW-1:0] ptr_o,
    input logic [PW-1:0] wb_addr_o,
    input logic [PW-1:0] off_q
);

    logic quiet_step;
    assign quiet_step = step_i & ~ld_ptr_i & ~ld_off_i & ~ld_mem_i;

    // R1: reset clears the pointer.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> ptr_o == '0);

    // R3: word-up step moves the pointer by +2.
    p_word_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_step && mode_i == 2'b00 |=> ptr_o == PW'($past(ptr_o) + 2));

    // R4: word-down step moves the pointer by -2.
    p_word_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_step && mode_i == 2'b01 |=> ptr_o == PW'($past(ptr_o) - 2));

    // R5: offset-up step adds the offset.
    p_offs_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_step && mode_i == 2'b10 |=> ptr_o == PW'($past(ptr_o) + $past(off_q)));

    // R6: offset-down step subtracts the offset.
    p_offs_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_step && mode_i == 2'b11 |=> ptr_o == PW'($past(ptr_o) - $past(off_q)));

    // R7: the offset register never holds an odd value after a load.
    p_off_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_off_i |=> off_q[0] == 1'b0);

    // R9: a step in a load cycle without pointer load leaves the pointer alone.
    p_load_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !ld_ptr_i && (ld_off_i || ld_mem_i) |=> $stable(ptr_o));

    // R10: write-back address is the mirror of the new pointer about the old one.
    p_wb_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_step |=> $past(wb_addr_o) == PW'(2 * $past(ptr_o) - ptr_o));

    // R11: no step and no load keeps the pointer.
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i && !ld_ptr_i |=> $stable(ptr_o));

endmodule

bind pdm_addr_unit pdm_addr_unit_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step_i),
    .mode_i    (mode_i),
    .ld_ptr_i  (ld_ptr_i),
    .ld_off_i  (ld_off_i),
    .ld_mem_i  (ld_mem_i),
    .ptr_o     (ptr_o),
    .wb_addr_o (wb_addr_o),
    .off_q     (off_q)
);

// File: tb/test_pdm_addr_unit.sv
// Bench for pdm_addr_unit: a behavioural reference model (array plus integers)
// updated and compared every clock.
module test_pdm_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        ld_ptr_i = 1'b0;
    logic [15:0] ld_ptr_val_i = '0;
    logic        ld_off_i = 1'b0;
    logic [15:0] ld_off_val_i = '0;
    logic        ld_mem_i = 1'b0;
    logic [15:0] ld_addr_i = '0;
    logic [15:0] ld_data_i = '0;
    logic [15:0] rd_data_o;
    logic [15:0] ptr_o;
    logic [15:0] wb_addr_o;

    int n_checks = 0;
    int n_fails  = 0;

    logic [15:0] m_mem [64];
    logic [15:0] m_ptr = '0;
    logic [15:0] m_off = '0;

    always #5 clk = ~clk;

    pdm_addr_unit i_pdm_addr_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (step_i),
        .mode_i       (mode_i),
        .ld_ptr_i     (ld_ptr_i),
        .ld_ptr_val_i (ld_ptr_val_i),
        .ld_off_i     (ld_off_i),
        .ld_off_val_i (ld_off_val_i),
        .ld_mem_i     (ld_mem_i),
        .ld_addr_i    (ld_addr_i),
        .ld_data_i    (ld_data_i),
        .rd_data_o    (rd_data_o),
        .ptr_o        (ptr_o),
        .wb_addr_o    (wb_addr_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int widx(input logic [15:0] a);
        return int'(a[6:1]);
    endfunction

    function automatic string mode_tag(input logic [1:0] md);
        case (md)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [15:0] exp_wb(input logic [15:0] p, input logic [15:0] o,
                                           input logic [1:0] md);
        logic [15:0] amt;
        amt = md[1] ? o : 16'd2;
        return md[0] ? 16'(p + amt) : 16'(p - amt);
    endfunction

    // One clock: drive, check combinational outputs, step model, check pointer.
    task automatic cyc(input bit st, input logic [1:0] md,
                       input bit lp, input logic [15:0] pv,
                       input bit lo, input logic [15:0] ov,
                       input bit lm, input logic [15:0] la, input logic [15:0] ldat);
        bit anyl;
        string ptag;
        logic [15:0] rd, amt;
        @(negedge clk);
        step_i = st; mode_i = md;
        ld_ptr_i = lp; ld_ptr_val_i = pv;
        ld_off_i = lo; ld_off_val_i = ov;
        ld_mem_i = lm; ld_addr_i = la; ld_data_i = ldat;
        #1;
        chk("R2 read word", rd_data_o, m_mem[widx(m_ptr)]);
        chk({"R10 wb ", mode_tag(md)}, wb_addr_o, exp_wb(m_ptr, m_off, md));
        anyl = lp | lo | lm;
        ptag = anyl ? (st ? "R9" : "R8 load") : (st ? mode_tag(md) : "R11");
        if (anyl) begin
            if (lp) m_ptr = pv;
            if (lo) m_off = {ov[15:1], 1'b0};
            if (lm) m_mem[widx(la)] = ldat;
        end else if (st) begin
            rd  = m_mem[widx(m_ptr)];
            amt = md[1] ? m_off : 16'd2;
            m_mem[widx(exp_wb(m_ptr, m_off, md))] = rd;
            m_ptr = md[0] ? 16'(m_ptr - amt) : 16'(m_ptr + amt);
        end
        @(posedge clk);
        #1;
        chk({ptag, " pointer"}, ptr_o, m_ptr);
    endtask

    // Read the whole table back by loading the pointer, then restore it.
    task automatic dump_check(input string req);
        logic [15:0] keep;
        keep = m_ptr;
        for (int i = 0; i < 64; i++) begin
            cyc(0, 2'b00, 1, 16'(2 * i), 0, 0, 0, 0, 0);
            @(negedge clk);
            #1;
            chk({req, " table"}, rd_data_o, m_mem[i]);
        end
        cyc(0, 2'b00, 1, keep, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        // R1: reset wins over a pointer load.
        rst_n = 1'b0;
        ld_ptr_i = 1'b1; ld_ptr_val_i = 16'h0055;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset pointer", ptr_o, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1; ld_ptr_i = 1'b0;

        // R8: fill, with bit 0 and wrap bits set on some addresses.
        for (int i = 0; i < 64; i++) begin
            logic [15:0] a;
            a = 16'(2 * i + ((i % 3 == 0) ? 128 : 0) + (i % 2));
            cyc(0, 2'b00, 0, 0, 0, 0, 1, a, 16'(16'hA000 + i * 37));
        end
        dump_check("R8");

        // R2: wrapped and odd pointers select the same word.
        cyc(0, 2'b00, 1, 16'h0085, 0, 0, 0, 0, 0);
        @(negedge clk); #1;
        chk("R2 odd wrapped pointer", rd_data_o, m_mem[2]);

        // R3: word-up run.
        cyc(0, 2'b00, 1, 16'd20, 0, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) cyc(1, 2'b00, 0, 0, 0, 0, 0, 0, 0);
        // R3 wrap past the table end.
        cyc(0, 2'b00, 1, 16'd124, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(1, 2'b00, 0, 0, 0, 0, 0, 0, 0);
        // R4: word-down run through zero.
        cyc(0, 2'b00, 1, 16'd4, 0, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) cyc(1, 2'b01, 0, 0, 0, 0, 0, 0, 0);
        dump_check("R4");

        // R7: odd offset load becomes 6; R5 and R6 runs.
        cyc(0, 2'b00, 0, 0, 1, 16'd7, 0, 0, 0);
        cyc(0, 2'b00, 1, 16'd40, 0, 0, 0, 0, 0);
        cyc(1, 2'b10, 0, 0, 0, 0, 0, 0, 0);
        chk("R7 even offset step", ptr_o, 16'd46);
        for (int i = 0; i < 5; i++) cyc(1, 2'b10, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 7; i++) cyc(1, 2'b11, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 2'b00, 0, 0, 1, 16'hFFF3, 0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(1, 2'b11, 0, 0, 0, 0, 0, 0, 0);
        dump_check("R6");

        // R5 with zero offset: write-back lands on the read word.
        cyc(0, 2'b00, 0, 0, 1, 16'd0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(1, 2'b10, 0, 0, 0, 0, 0, 0, 0);

        // R9: step together with each kind of load.
        cyc(0, 2'b00, 0, 0, 1, 16'd4, 0, 0, 0);
        cyc(0, 2'b00, 1, 16'd30, 0, 0, 0, 0, 0);
        cyc(1, 2'b00, 0, 0, 0, 0, 1, 16'd28, 16'h1234);
        cyc(1, 2'b10, 0, 0, 0, 0, 1, 16'd90, 16'h5678);
        cyc(1, 2'b01, 1, 16'd50, 0, 0, 0, 0, 0);
        cyc(1, 2'b11, 0, 0, 1, 16'd10, 0, 0, 0);
        dump_check("R9");

        // R11: idle cycles with mode and data toggling.
        for (int i = 0; i < 6; i++) cyc(0, 2'(i), 0, 0, 0, 0, 0, 16'(i), 16'hDEAD);
        dump_check("R11");

        // Mixed random run.
        for (int i = 0; i < 1500; i++) begin
            int r;
            r = int'($urandom_range(0, 19));
            cyc($urandom_range(0, 3) != 0, 2'($urandom()),
                r == 0, 16'($urandom()),
                r == 1, 16'($urandom_range(0, 20)),
                r == 2 || r == 3, 16'($urandom()), 16'($urandom()));
        end
        dump_check("R2");

        finish_run();
    end

endmodule